// File: doc/BRIEF.md
# Load Data Width Conversion Unit

This unit sits after the data read of a vector load and turns the raw bytes into one destination element. The memory side gives a 64-bit word whose low bytes hold the value at the operation width of 8, 16, 32 or 64 bits. The unit first swaps the byte order of that value when the instruction's byte-reverse flag and the processor's little-endian flag agree. It then resizes the value to the source element width. Last, it either resizes it again to the destination element width or clamps it into that width.

In plain mode both resizes zero-extend or drop upper bits. In saturating mode the value is sign-extended or truncated to the source element width and then clamped at the destination width, as signed or as unsigned. The result leaves a register one cycle after a valid strobe. It is right-aligned, and every bit above the destination width is zero. Placing the element in the register file is done elsewhere.

Top module: `ldconv_unit`

## Requirements
- R1: `out_valid` equals `in_valid` of the previous clock. `out_data` loads a new result only on a cycle where `in_valid` is 1, and otherwise keeps its value.
- R2: While `rst_n` is low, `out_valid` and `out_data` are 0.
- R3: The width codes on `op_wid`, `src_wid` and `dst_wid` are 2'b00=8, 2'b01=16, 2'b10=32 and 2'b11=64 bits. Bits of `raw_data` above the operation width have no effect on the result.
- R4: The bytes inside the operation width are reversed exactly when `brev_insn` equals `le_mode`. The reversal comes before any width change.
- R5: With `sat_en`=0, the value is zero-extended or truncated from the operation width to the source width, then zero-extended or truncated to the destination width.
- R6: With `sat_en`=1, the value is sign-extended or truncated from the operation width to the source width and read as a signed source-width number.
- R7: With `sat_en`=1 and `sat_signed`=1, values above 2^(d-1)-1 give that maximum and values below -2^(d-1) give that minimum, where d is the destination width.
- R8: With `sat_en`=1 and `sat_signed`=0, negative values give 0, values above 2^d-1 give all ones, and other values pass unchanged.
- R9: Bits of `out_data` above the destination width are 0. Signed results are two's complement inside the destination width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input strobe |
| raw_data | input | 64 | Data as read from memory, right-aligned at operation width |
| op_wid | input | 2 | Operation width code |
| src_wid | input | 2 | Source element width code |
| dst_wid | input | 2 | Destination element width code |
| brev_insn | input | 1 | Byte-reverse instruction flag |
| le_mode | input | 1 | Processor little-endian flag |
| sat_en | input | 1 | Saturating mode |
| sat_signed | input | 1 | 1 = signed saturation, 0 = unsigned |
| out_valid | output | 1 | Result strobe |
| out_data | output | 64 | Converted element, right-aligned at destination width |

## Verification
The bench builds the unit at its default 64-bit data path. That path covers all 64 combinations of the three width codes together with both byte-order flags and the three conversion modes. Random stimulus spreads over every width triple with random data, so both growing and shrinking steps occur in each mode. Directed cases then pin down the clamp edges, the order of swap before resize, and the hold behaviour while the strobe is low.

// File: rtl/ldconv_pkg.sv
package ldconv_pkg;
  localparam int LDC_W     = 64;
  localparam int LDC_BYTES = LDC_W / 8;
  localparam int WCODE_W   = 2;

  // width in bits for a 2-bit width code
  function automatic logic [6:0] wid_bits(input logic [WCODE_W-1:0] c);
    return 7'd8 << c;
  endfunction

  // low-bit mask covering a width code
  function automatic logic [LDC_W-1:0] wid_mask(input logic [WCODE_W-1:0] c);
    logic [LDC_W-1:0] m;
    if (c == 2'b11) m = '1;
    else            m = (64'd1 << wid_bits(c)) - 64'd1;
    return m;
  endfunction

  // reverse byte order within the low (8 << c) bits, upper bits cleared
  function automatic logic [LDC_W-1:0] byte_swap(input logic [LDC_W-1:0] d,
                                                 input logic [WCODE_W-1:0] c);
    logic [LDC_W-1:0] r;
    int nb;
    r  = '0;
    nb = 1 << c;
    for (int b = 0; b < LDC_BYTES; b++) begin
      if (b < nb) r[8*b +: 8] = d[8*(nb-1-b) +: 8];
    end
    return r;
  endfunction

  // sign-extend from the width of code c to the full data path
  function automatic logic [LDC_W-1:0] sign_ext(input logic [LDC_W-1:0] d,
                                                input logic [WCODE_W-1:0] c);
    logic [LDC_W-1:0] t;
    int sh;
    sh = LDC_W - int'(wid_bits(c));
    t  = d << sh;
    return LDC_W'($signed(t) >>> sh);
  endfunction
endpackage

// File: rtl/ldconv_swap.sv
module ldconv_swap
  import ldconv_pkg::*;
(
  input  logic [LDC_W-1:0]   raw_data,
  input  logic [WCODE_W-1:0] op_wid,
  input  logic               brev_insn,
  input  logic               le_mode,
  output logic [LDC_W-1:0]   op_val,
  output logic               swap_active
);
  logic [LDC_W-1:0] clipped;

  assign swap_active = ~(brev_insn ^ le_mode);
  assign clipped     = raw_data & wid_mask(op_wid);

  always_comb begin
    if (swap_active) op_val = byte_swap(clipped, op_wid);
    else             op_val = clipped;
  end
endmodule

// File: rtl/ldconv_src.sv
module ldconv_src
  import ldconv_pkg::*;
(
  input  logic [LDC_W-1:0]   op_val,
  input  logic [WCODE_W-1:0] op_wid,
  input  logic [WCODE_W-1:0] src_wid,
  input  logic               sat_en,
  output logic [LDC_W-1:0]   src_val
);
  logic [LDC_W-1:0] sx_op;

  // signed view at op width, then re-read at src width (truncates or keeps)
  assign sx_op = sign_ext(op_val, op_wid);

  always_comb begin
    if (sat_en) src_val = sign_ext(sx_op, src_wid);
    else        src_val = op_val & wid_mask(src_wid);
  end
endmodule

// File: rtl/ldconv_dst.sv
module ldconv_dst
  import ldconv_pkg::*;
(
  input  logic [LDC_W-1:0]   src_val,
  input  logic [WCODE_W-1:0] dst_wid,
  input  logic               sat_en,
  input  logic               sat_signed,
  output logic [LDC_W-1:0]   dst_val,
  output logic               sat_hi,
  output logic               sat_lo
);
  logic signed [LDC_W-1:0] sv;
  logic signed [LDC_W-1:0] s_max;
  logic signed [LDC_W-1:0] s_min;
  logic        [LDC_W-1:0] dmask;
  logic        [LDC_W-1:0] pre;

  assign sv    = $signed(src_val);
  assign dmask = wid_mask(dst_wid);
  assign s_max = $signed((64'd1 << (wid_bits(dst_wid) - 7'd1)) - 64'd1);
  assign s_min = ~s_max;

  always_comb begin
    sat_hi = 1'b0;
    sat_lo = 1'b0;
    pre    = src_val;
    if (sat_en) begin
      if (sat_signed) begin
        if (sv > s_max) begin
          sat_hi = 1'b1;
          pre    = s_max;
        end else if (sv < s_min) begin
          sat_lo = 1'b1;
          pre    = s_min;
        end
      end else begin
        if (sv < 0) begin
          sat_lo = 1'b1;
          pre    = '0;
        end else if (dst_wid != 2'b11 && src_val > dmask) begin
          sat_hi = 1'b1;
          pre    = dmask;
        end
      end
    end
  end

  assign dst_val = pre & dmask;
endmodule

// File: rtl/ldconv_unit.sv
module ldconv_unit
  import ldconv_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [LDC_W-1:0]   raw_data,
  input  logic [WCODE_W-1:0] op_wid,
  input  logic [WCODE_W-1:0] src_wid,
  input  logic [WCODE_W-1:0] dst_wid,
  input  logic               brev_insn,
  input  logic               le_mode,
  input  logic               sat_en,
  input  logic               sat_signed,
  output logic               out_valid,
  output logic [LDC_W-1:0]   out_data
);
  logic [LDC_W-1:0] op_val;
  logic [LDC_W-1:0] src_val;
  logic [LDC_W-1:0] dst_val;
  logic             swap_active;
  logic             sat_hi;
  logic             sat_lo;

  ldconv_swap u_swap (
    .raw_data    (raw_data),
    .op_wid      (op_wid),
    .brev_insn   (brev_insn),
    .le_mode     (le_mode),
    .op_val      (op_val),
    .swap_active (swap_active)
  );

  ldconv_src u_src (
    .op_val  (op_val),
    .op_wid  (op_wid),
    .src_wid (src_wid),
    .sat_en  (sat_en),
    .src_val (src_val)
  );

  ldconv_dst u_dst (
    .src_val    (src_val),
    .dst_wid    (dst_wid),
    .sat_en     (sat_en),
    .sat_signed (sat_signed),
    .dst_val    (dst_val),
    .sat_hi     (sat_hi),
    .sat_lo     (sat_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= dst_val;
    end
  end
endmodule

// File: rtl/ldconv_chk.sv
module ldconv_chk
  import ldconv_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [LDC_W-1:0]   raw_data,
  input logic [WCODE_W-1:0] op_wid,
  input logic [WCODE_W-1:0] src_wid,
  input logic [WCODE_W-1:0] dst_wid,
  input logic               sat_en,
  input logic               sat_signed,
  input logic               sat_hi,
  input logic               sat_lo,
  input logic               out_valid,
  input logic [LDC_W-1:0]   out_data
);
  logic live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (out_valid == $past(in_valid)));

  a_r1_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !in_valid) |=> $stable(out_data));

  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (live && in_valid) |=> ((out_data & ~wid_mask($past(dst_wid))) == '0));

  a_r7_clamp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sat_hi, sat_lo}));

  a_r5_no_clamp_plain: assert property (@(posedge clk) disable iff (!rst_n)
    !sat_en |-> (!sat_hi && !sat_lo));

  a_r8_neg_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (live && in_valid && sat_en && !sat_signed && sat_lo) |=> (out_data == '0));

  a_r3_byte_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (live && in_valid && op_wid == 2'b00 && !sat_en && src_wid == 2'b11 && dst_wid == 2'b11)
      |=> (out_data == {56'd0, $past(raw_data[7:0])}));
endmodule

bind ldconv_unit ldconv_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .raw_data   (raw_data),
  .op_wid     (op_wid),
  .src_wid    (src_wid),
  .dst_wid    (dst_wid),
  .sat_en     (sat_en),
  .sat_signed (sat_signed),
  .sat_hi     (sat_hi),
  .sat_lo     (sat_lo),
  .out_valid  (out_valid),
  .out_data   (out_data)
);

// File: tb/ldconv_unit_tb.sv
module ldconv_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] raw_data = '0;
  logic [1:0]  op_wid = '0, src_wid = '0, dst_wid = '0;
  logic        brev_insn = 1'b0, le_mode = 1'b0, sat_en = 1'b0, sat_signed = 1'b0;
  logic        out_valid;
  logic [63:0] out_data;

  int n_cmp = 0;
  int n_bad = 0;
  logic [63:0] held = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldconv_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .raw_data(raw_data),
    .op_wid(op_wid), .src_wid(src_wid), .dst_wid(dst_wid),
    .brev_insn(brev_insn), .le_mode(le_mode), .sat_en(sat_en),
    .sat_signed(sat_signed), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [63:0] bmask(int w);
    if (w >= 64) return '1;
    return (64'd1 << w) - 64'd1;
  endfunction

  function automatic longint as_signed(logic [63:0] v, int w);
    logic [63:0] t;
    t = v & bmask(w);
    if (t[w-1]) t = t | ~bmask(w);
    return longint'(t);
  endfunction

  function automatic logic [63:0] model(logic [63:0] raw, logic [1:0] op, logic [1:0] sw_c,
                                        logic [1:0] dw_c, logic br, logic le,
                                        logic sat, logic sgn);
    int ow, sw, dw;
    logic [63:0] v, r;
    longint s, hi, lo;
    ow = 8 << op; sw = 8 << sw_c; dw = 8 << dw_c;
    v = raw & bmask(ow);
    if (br == le) begin
      r = '0;
      for (int k = 0; k < ow/8; k++) r = (r << 8) | ((v >> (8*k)) & 64'hff);
      v = r;
    end
    if (!sat) return v & bmask(sw) & bmask(dw);
    s = as_signed(v, ow);
    s = as_signed(64'(s), sw);
    if (sgn) begin
      if (dw < 64) begin
        hi = longint'(bmask(dw-1));
        lo = -hi - 1;
        if (s > hi) s = hi;
        else if (s < lo) s = lo;
      end
    end else begin
      if (s < 0) s = 0;
      else if (dw < 64 && s > longint'(bmask(dw))) s = longint'(bmask(dw));
    end
    return 64'(s) & bmask(dw);
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, check the registered result at the following negedge
  task automatic step(string tag, bit v, logic [63:0] raw, logic [1:0] op, logic [1:0] sw,
                      logic [1:0] dw, bit br, bit le, bit sat, bit sgn);
    logic [63:0] exp;
    in_valid = v; raw_data = raw; op_wid = op; src_wid = sw; dst_wid = dw;
    brev_insn = br; le_mode = le; sat_en = sat; sat_signed = sgn;
    exp = v ? model(raw, op, sw, dw, br, le, sat, sgn) : held;
    @(negedge clk);
    check("R1 valid", {63'd0, out_valid}, {63'd0, v});
    check(tag, out_data, exp);
    held = exp;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 20240611;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R2 reset valid", {63'd0, out_valid}, 64'd0);
    check("R2 reset data", out_data, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: swap when flags equal, none when they differ
    step("R4 swap", 1, 64'h0000_0000_0000_1234, 2'b01, 2'b11, 2'b11, 1, 1, 0, 0);
    check("R4 swap value", out_data, 64'h3412);
    step("R4 noswap", 1, 64'h0000_0000_0000_1234, 2'b01, 2'b11, 2'b11, 0, 1, 0, 0);
    check("R4 noswap value", out_data, 64'h1234);
    // R3: upper raw bits ignored
    step("R3 upper ignored", 1, 64'hDEAD_BEEF_0000_1234, 2'b01, 2'b11, 2'b11, 1, 0, 0, 0);
    check("R3 value", out_data, 64'h1234);
    // R5: truncate at source, zero-extend at destination
    step("R5 plain", 1, 64'h0000_0000_89AB_CDEF, 2'b10, 2'b01, 2'b11, 0, 1, 0, 0);
    check("R5 value", out_data, 64'hCDEF);
    // R7 / R9 signed clamps and in-range negatives
    step("R9 neg8", 1, 64'h80, 2'b00, 2'b11, 2'b01, 0, 1, 1, 1);
    check("R9 value", out_data, 64'hFF80);
    step("R7 max", 1, 64'h0001_2345, 2'b10, 2'b10, 2'b01, 0, 1, 1, 1);
    check("R7 max value", out_data, 64'h7FFF);
    step("R7 min", 1, 64'hFFFE_0000, 2'b10, 2'b10, 2'b01, 0, 1, 1, 1);
    check("R7 min value", out_data, 64'h8000);
    // R8 unsigned clamps
    step("R8 neg", 1, 64'h8000, 2'b01, 2'b10, 2'b01, 0, 1, 1, 0);
    check("R8 zero", out_data, 64'h0);
    step("R8 big", 1, 64'h0001_2345, 2'b10, 2'b10, 2'b01, 0, 1, 1, 0);
    check("R8 ones", out_data, 64'hFFFF);
    // R6: truncation to smaller source before clamp
    step("R6 trunc", 1, 64'h8001, 2'b01, 2'b00, 2'b00, 0, 1, 1, 1);
    check("R6 value", out_data, 64'h01);
    // R4 order: swap before saturation
    step("R4 order", 1, 64'h0080, 2'b01, 2'b11, 2'b00, 1, 1, 1, 1);
    check("R4 order value", out_data, 64'h80);
    // R1 hold while strobe low
    step("R1 hold", 0, 64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 2'b11, 2'b11, 0, 1, 0, 0);
    check("R1 held value", out_data, 64'h80);

    for (int n = 0; n < 3000; n++) begin
      logic [63:0] rd;
      logic [1:0] o, s, d;
      bit sat, sg;
      rd  = {$urandom, $urandom};
      o   = 2'($urandom); s = 2'($urandom); d = 2'($urandom);
      sat = ($urandom % 3) != 0; sg = 1'($urandom);
      step(sat ? (sg ? "R7 random" : "R8 random") : "R5 random",
           ($urandom % 5) != 0, rd, o, s, d, 1'($urandom), 1'($urandom), sat, sg);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule